// File: doc/BRIEF.md
# Banked Extended-Address Generator

This block sits beside a 6502-class processor and adds two high address bits, so the processor reaches 256 KB of memory. It watches the bus, recognises the two indirect zero-page addressing modes (pointer plus Y, and pointer alone), and counts bus cycles from each opcode fetch. Only during the data accesses of those instructions does it drive a nonzero bank onto `ext_addr`. Every other cycle gets bank 0: opcode fetches, operand fetches, pointer reads and all other instructions.

The bank for an instruction comes from a small shadow table of 2-bit entries. The table is filled by snooping processor writes to page 3 of bank 0. The entry used is the one indexed by the zero-page operand plus one, which is the pointer's high-byte location. In the default banked mode, the pointer plus Y wraps inside the selected 64 KB bank. In flat mode, a carry out of address bit 15 moves the access into the next bank. To gain time for that correction, the block holds the processor for one bus cycle through its ready output.

Top module: `ext_bank_gen`

## Requirements
- R1: Reset drives `ext_addr` to 0 and `rdy` high, clears the cycle position and the latched mode, and clears every shadow entry to 0, so an entry never written yields bank 0.
- R2: A completed bus write (`cpu_en`=1, `rw`=0, `rdy`=1) to 0x0300–0x03FF while `ext_addr` is 0 stores `data[1:0]` into entry `addr[7:0]`. The same write while `ext_addr` is nonzero leaves the table unchanged.
- R3: Only an opcode whose low five bits are 10001 (pointer plus Y) or 10010 (pointer alone) triggers extension. Any other opcode keeps `ext_addr` at 0 for the whole instruction.
- R4: The bank applied is the entry at index (operand + 1) mod 256, where the operand is the byte read in the bus cycle after the opcode fetch.
- R5: `ext_addr` is 0 during the opcode fetch and the three bus cycles after it. The bank is applied from the fourth bus cycle after the opcode fetch onward, and it drops to 0 in the same cycle that `sync` next rises, so a load that skips its final read does not leak the bank.
- R6: With `turbo_en` low, `ext_addr` is 0 and `rdy` is high on every cycle.
- R7: In banked mode, the bank never changes while the instruction runs, even when pointer + Y passes 0xFFFF. For example, pointer 0xFFFF, Y=1 and bank 2 reach bank 2, address 0x0000.
- R8: In flat mode, a data-phase cycle whose pointer high byte (read from operand+1) has bit 7 set while `addr[15]` is 0 is given bank + 1 modulo 4.
- R9: The first such carry cycle of an instruction holds `rdy` low for exactly one enabled bus cycle and shows the unincremented bank. The repeated cycle shows the incremented bank with `rdy` high, and no further stall occurs in that instruction.
- R10: All state advances only on clocks with `cpu_en` high. Clocks with `cpu_en` low change nothing, and at most one cycle-position marker is set at a time.
- R11: `flat_mode` is sampled only in the opcode-fetch cycle. Changes later in the instruction have no effect until the next opcode fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_en | input | 1 | High on the clock that ends a processor bus cycle |
| addr | input | 16 | Processor address bus |
| data | input | 8 | Processor data bus (read or write data) |
| sync | input | 1 | High during an opcode fetch |
| rw | input | 1 | 1 = read, 0 = write |
| turbo_en | input | 1 | Enables bank extension |
| flat_mode | input | 1 | 1 = carry from bit 15 into the bank, 0 = 64 KB wrap |
| ext_addr | output | 2 | Extra address bits 17:16 |
| rdy | output | 1 | Low requests a one-cycle processor stall |

## Verification
The bench targets pointer + Y crossing a page boundary at 0xFFFF in both modes. A design that carried in banked mode would show bank 3 where bank 2 is correct. A design without flat-mode carry would keep bank 2 and never drop `rdy`. A design that stalled twice, or showed the corrected bank during the stall, fails the cycle-exact checks around the stall. Loads without a page cross, followed at once by a new opcode fetch, expose a bank that outlives the instruction. Flat carries from bank 3 must wrap to 0. A page-3 store issued while a nonzero bank is applied must not alter the table, which a later lookup of that entry reveals. Random idle clocks, and `flat_mode` changed after the fetch, catch designs that count raw clocks or sample the mode late.

// File: rtl/ext_bank_pkg.sv
`timescale 1ns/1ps
package ext_bank_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int BANK_W   = 2;
    localparam logic [7:0] SHADOW_PAGE = 8'h03;

    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_IND_Y = 2'd1,
        MODE_IND   = 2'd2
    } ind_mode_e;

    // Per-instruction context captured while the instruction runs
    typedef struct packed {
        logic  trig;
        logic  flat;
        bank_t bank;
        logic  ptr_msb;
    } instr_ctx_t;

    function automatic ind_mode_e decode_mode(input logic [DATA_W-1:0] op);
        case (op[4:0])
            5'b10001: return MODE_IND_Y;
            5'b10010: return MODE_IND;
            default:  return MODE_NONE;
        endcase
    endfunction

    function automatic bank_t bank_step(input bank_t b);
        return b + bank_t'(1);
    endfunction

endpackage

// File: rtl/ext_sync_tracker.sv
`timescale 1ns/1ps
module ext_sync_tracker #(
    parameter int TRACK_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_en,
    input  logic                 sync,
    output logic [TRACK_LEN-1:0] stage
);

    // stage[k] marks the (k+1)-th bus cycle after the latest opcode fetch
    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else if (cpu_en) begin
            if (sync) stage <= TRACK_LEN'(1);
            else      stage <= {stage[TRACK_LEN-2:0], 1'b0};
        end
    end

    AST_STAGE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage)); // R10

endmodule

// File: rtl/ext_page3_mirror.sv
`timescale 1ns/1ps
module ext_page3_mirror #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [ENTRY_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)                            entry[i] <= '0;
            else if (we && waddr == IDX_W'(i))  entry[i] <= wdata;
        end
    end

    assign rdata = entry[raddr];

    AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> (raddr != $past(raddr) || rdata == $past(rdata))); // R2

endmodule

// File: rtl/ext_bank_ctrl.sv
`timescale 1ns/1ps
module ext_bank_ctrl
    import ext_bank_pkg::*;
#(
    parameter int TRACK_LEN   = 8,
    parameter int APPLY_STAGE = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_en,
    input  logic                 sync,
    input  logic                 addr_msb,
    input  logic [DATA_W-1:0]    data,
    input  logic                 turbo_en,
    input  logic                 flat_mode,
    input  logic [TRACK_LEN-1:0] stage,
    input  bank_t                mirror_rdata,
    output logic [DATA_W-1:0]    mirror_raddr,
    output bank_t                ext_addr,
    output logic                 rdy
);

    localparam int OPER_STAGE  = 0;
    localparam int PTRHI_STAGE = APPLY_STAGE - 1;

    instr_ctx_t ctx;
    logic       active;
    logic       stall_done;
    logic       apply_on;
    logic       carry;

    // Pointer high byte lives at operand + 1 (wraps in zero page)
    assign mirror_raddr = data + 1'b1;

    always_comb begin
        apply_on = turbo_en && active && !sync;
        carry    = ctx.flat && ctx.ptr_msb && !addr_msb;
        rdy      = !(apply_on && carry && !stall_done);
        ext_addr = '0;
        if (apply_on)
            ext_addr = (carry && stall_done) ? bank_step(ctx.bank) : ctx.bank;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx        <= '0;
            active     <= 1'b0;
            stall_done <= 1'b0;
        end else if (cpu_en) begin
            if (sync) begin
                ctx.trig   <= (decode_mode(data) != MODE_NONE);
                ctx.flat   <= flat_mode;
                active     <= 1'b0;
                stall_done <= 1'b0;
            end else begin
                if (stage[OPER_STAGE])
                    ctx.bank <= mirror_rdata;
                if (stage[PTRHI_STAGE]) begin
                    ctx.ptr_msb <= data[DATA_W-1];
                    active      <= ctx.trig;
                end
                if (!rdy)
                    stall_done <= 1'b1;
            end
        end
    end

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && !rdy) |=> rdy); // R9

    AST_CARRY_STEP: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && !rdy) |=> (!$stable(addr_msb) || !turbo_en || sync ||
                               ext_addr == bank_step($past(ext_addr)))); // R8

    AST_EARLY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (|stage[APPLY_STAGE-1:0]) |-> ext_addr == '0); // R5

    AST_TURBO_GATE: assert property (@(posedge clk) disable iff (rst)
        !turbo_en |-> (ext_addr == '0 && rdy)); // R6

endmodule

// File: rtl/ext_bank_gen.sv
`timescale 1ns/1ps
module ext_bank_gen
    import ext_bank_pkg::*;
#(
    parameter int TRACK_LEN   = 8,
    parameter int APPLY_STAGE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              sync,
    input  logic              rw,
    input  logic              turbo_en,
    input  logic              flat_mode,
    output logic [BANK_W-1:0] ext_addr,
    output logic              rdy
);

    localparam int PAGE_W = ADDR_W - DATA_W;

    logic [TRACK_LEN-1:0] stage;
    logic [DATA_W-1:0]    mirror_raddr;
    bank_t                mirror_rdata;
    bank_t                bank_out;
    logic                 mirror_we;

    ext_sync_tracker #(.TRACK_LEN(TRACK_LEN)) u_tracker (
        .clk    (clk),
        .rst    (rst),
        .cpu_en (cpu_en),
        .sync   (sync),
        .stage  (stage)
    );

    // Snoop completed writes to the shadowed page of bank 0
    assign mirror_we = cpu_en && !rw && rdy && (bank_out == '0) &&
                       (addr[ADDR_W-1:DATA_W] == PAGE_W'(SHADOW_PAGE));

    ext_page3_mirror #(.IDX_W(DATA_W), .ENTRY_W(BANK_W)) u_mirror (
        .clk   (clk),
        .rst   (rst),
        .we    (mirror_we),
        .waddr (addr[DATA_W-1:0]),
        .wdata (data[BANK_W-1:0]),
        .raddr (mirror_raddr),
        .rdata (mirror_rdata)
    );

    ext_bank_ctrl #(.TRACK_LEN(TRACK_LEN), .APPLY_STAGE(APPLY_STAGE)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cpu_en       (cpu_en),
        .sync         (sync),
        .addr_msb     (addr[ADDR_W-1]),
        .data         (data),
        .turbo_en     (turbo_en),
        .flat_mode    (flat_mode),
        .stage        (stage),
        .mirror_rdata (mirror_rdata),
        .mirror_raddr (mirror_raddr),
        .ext_addr     (bank_out),
        .rdy          (rdy)
    );

    assign ext_addr = bank_out;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (ext_addr == '0 && rdy)); // R1

endmodule

// File: tb/ext_bank_gen_bench.sv
`timescale 1ns/1ps
module ext_bank_gen_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_en;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        sync;
    logic        rw;
    logic        turbo_en;
    logic        flat_mode;
    logic [1:0]  ext_addr;
    logic        rdy;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    bit   st_done;
    logic [1:0] mdl [256];

    always #2.5 clk = ~clk;

    ext_bank_gen u_ext_bank_gen (
        .clk(clk), .rst(rst), .cpu_en(cpu_en), .addr(addr), .data(data),
        .sync(sync), .rw(rw), .turbo_en(turbo_en), .flat_mode(flat_mode),
        .ext_addr(ext_addr), .rdy(rdy)
    );

    task automatic chk(input logic [1:0] ge, input logic [1:0] ee,
                       input logic gr, input logic er, input string tag);
        n_cmp++;
        if (ge !== ee || gr !== er) begin
            n_bad++;
            $display("FAIL %s: ext=%0d rdy=%0b expected ext=%0d rdy=%0b",
                     tag, ge, gr, ee, er);
        end
    endtask

    // One bus cycle with random idle clocks before its enabled clock
    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic s,
                       input logic r, input logic [1:0] ee, input logic er,
                       input string tag);
        @(negedge clk);
        addr = a; data = d; sync = s; rw = r; cpu_en = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        cpu_en = 1'b1;
        #1;
        chk(ext_addr, ee, rdy, er, tag);
        @(posedge clk);
        #1;
        cpu_en = 1'b0;
    endtask

    task automatic data_cyc(input logic [15:0] a, input logic r, input logic [1:0] bk,
                            input logic fl, input logic hi7, input logic tb);
        logic [7:0] d;
        logic       cy;
        logic [1:0] e;
        d  = 8'($urandom);
        cy = tb && fl && hi7 && !a[15];
        if (cy && !st_done) begin
            bus(a, d, 1'b0, r, bk, 1'b0, "R9 stall cycle");
            st_done = 1'b1;
        end
        e = cy ? bk + 2'd1 : bk;
        bus(a, d, 1'b0, r, e, 1'b1, cy ? "R8 flat carry" : "R4/R7 bank applied");
        if (!r && a[15:8] == 8'h03 && e == 2'd0) mdl[a[7:0]] = d[1:0];
    endtask

    task automatic run_ind(input logic ymode, input logic [7:0] zp, input logic [15:0] ptr,
                           input logic [7:0] y, input logic st, input logic tb,
                           input logic fl);
        logic [7:0]  op;
        logic [7:0]  zp1;
        logic [1:0]  bk;
        logic [8:0]  lo;
        logic [15:0] eff;
        logic [15:0] pc;
        op  = {st ? 3'b100 : 3'b101, ymode ? 5'b10001 : 5'b10010};
        zp1 = zp + 8'd1;
        bk  = tb ? mdl[zp1] : 2'd0;
        pc  = 16'h1000 + 16'($urandom_range(0, 255));
        turbo_en  = tb;
        flat_mode = fl;
        bus(pc, op, 1'b1, 1'b1, 2'd0, 1'b1, "R5 opcode fetch");
        flat_mode = 1'($urandom); // R11: late change must be ignored
        bus(pc + 16'd1, zp, 1'b0, 1'b1, 2'd0, 1'b1, "R5 operand fetch");
        bus({8'h00, zp}, ptr[7:0], 1'b0, 1'b1, 2'd0, 1'b1, "R5 pointer low");
        bus({8'h00, zp1}, ptr[15:8], 1'b0, 1'b1, 2'd0, 1'b1, "R5 pointer high");
        st_done = 1'b0;
        if (ymode) begin
            lo  = {1'b0, ptr[7:0]} + {1'b0, y};
            eff = ptr + {8'h00, y};
            if (lo[8] || st) data_cyc({ptr[15:8], lo[7:0]}, 1'b1, bk, fl, ptr[15], tb);
            data_cyc(eff, !st, bk, fl, ptr[15], tb);
        end else begin
            data_cyc(ptr, !st, bk, fl, ptr[15], tb);
        end
    endtask

    // Non-triggering instruction: random bus traffic, bank must stay 0 (R3)
    task automatic run_plain(input logic [7:0] op);
        logic [15:0] a;
        logic [7:0]  d;
        logic        r;
        turbo_en  = 1'($urandom);
        flat_mode = 1'($urandom);
        bus(16'h1800, op, 1'b1, 1'b1, 2'd0, 1'b1, "R3 plain fetch");
        for (int k = 0; k < 4; k++) begin
            a = 16'($urandom);
            r = 1'b1;
            if ($urandom_range(0, 3) == 0) begin
                a[15:8] = 8'h03;
                r = 1'b0;
            end
            d = 8'($urandom);
            bus(a, d, 1'b0, r, 2'd0, 1'b1, "R3 plain cycle");
            if (!r && a[15:8] == 8'h03) mdl[a[7:0]] = d[1:0];
        end
    endtask

    // Store to a shadow entry through an absolute store (opcode 0x8D)
    task automatic poke(input logic [7:0] idx, input logic [1:0] val);
        turbo_en = 1'b1;
        bus(16'h1900, 8'h8D, 1'b1, 1'b1, 2'd0, 1'b1, "R3 store fetch");
        bus(16'h1901, idx, 1'b0, 1'b1, 2'd0, 1'b1, "R3 store operand");
        bus(16'h1902, 8'h03, 1'b0, 1'b1, 2'd0, 1'b1, "R3 store operand");
        bus({8'h03, idx}, {6'b101010, val}, 1'b0, 1'b0, 2'd0, 1'b1, "R2 shadow write");
        mdl[idx] = val;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mdl[i] = 2'd0;
        rst = 1'b1; cpu_en = 1'b0; addr = '0; data = '0; sync = 1'b0;
        rw = 1'b1; turbo_en = 1'b1; flat_mode = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        #1 chk(ext_addr, 2'd0, rdy, 1'b1, "R1 reset state");

        // R1: untouched entry gives bank 0
        run_ind(1'b1, 8'h40, 16'hFFFF, 8'h01, 1'b0, 1'b1, 1'b0);
        // R7: banked wrap at 0xFFFF keeps bank 2
        poke(8'h81, 2'd2);
        run_ind(1'b1, 8'h80, 16'hFFFF, 8'h01, 1'b0, 1'b1, 1'b0);
        // R8/R9: flat carry 2 -> 3 with one stall
        run_ind(1'b1, 8'h80, 16'hFFFF, 8'h01, 1'b0, 1'b1, 1'b1);
        // R8: flat carry from bank 3 wraps to 0
        poke(8'h81, 2'd3);
        run_ind(1'b1, 8'h80, 16'hFFF0, 8'h20, 1'b0, 1'b1, 1'b1);
        // R4: pointer-alone store
        run_ind(1'b0, 8'h80, 16'h8123, 8'h00, 1'b1, 1'b1, 1'b1);
        // R6: turbo off hides a nonzero bank
        run_ind(1'b1, 8'h80, 16'hFFFF, 8'h01, 1'b0, 1'b0, 1'b1);
        // R2: page-3 store while bank 1 is applied must not update entry 0x90
        poke(8'h91, 2'd1);
        run_ind(1'b1, 8'h90, 16'h0380, 8'h10, 1'b1, 1'b1, 1'b0);
        run_ind(1'b1, 8'h8F, 16'h1234, 8'h00, 1'b0, 1'b1, 1'b0);
        // R5: short load followed at once by a fetch
        run_ind(1'b1, 8'h80, 16'h4000, 8'h05, 1'b0, 1'b1, 1'b0);
        run_plain(8'hEA);

        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                logic [7:0] op;
                op = 8'($urandom);
                if (op[4:0] == 5'b10001 || op[4:0] == 5'b10010) op[0] = ~op[0];
                run_plain(op);
            end else begin
                logic [15:0] p;
                p = 16'($urandom);
                if ($urandom_range(0, 2) == 0) p[15:8] = 8'hFF;
                run_ind(1'($urandom), 8'($urandom), p, 8'($urandom),
                        1'($urandom), ($urandom_range(0, 4) != 0), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule